// File: doc/BRIEF.md
# System Clock Source and Low-Power Mode Controller

This block manages the system clock of a small microcontroller through one 8-bit control register. Software picks either the low-speed clock or the high-speed clock, undivided or divided by a power of two, and reads two flags that tell whether each oscillator has settled. The flags come from settle counters whose length depends on the oscillator type of the high-speed source. The clock choice is brought out as a source select and a divider exponent; the actual switching of clocks is left to logic outside the block.

When the CPU signals a halt, the block resolves the request into one of three low-power states from a register bit and a separate peripheral-keep input. It drops the CPU-run enable and, where the state calls for it, the system-clock enable. A wake-up input returns the block to run mode. An optional fast-wake setting lets a crystal-driven system run from the low-speed clock until the high-speed oscillator reports ready.

Top module: `clk_pmode_ctrl`

## Requirements
- R1: After reset the register reads 8'h03, `pwr_mode` is 0 (run), and `cpu_run` and `sys_clk_en` are both 1.
- R2: Register read layout from bit 7 down to bit 0 is: divider code [7:5], fast-wake enable [4], low-speed ready [3], high-speed ready [2], idle enable [1], high-speed direct [0]. A write stores bits 7:4 and 1:0 and is visible on the next cycle; bits 3:2 ignore writes.
- R3: With high-speed direct (bit 0) set and no fast-wake override, `src_low` is 0 and `div_log2` is 0.
- R4: With bit 0 clear, divider code 0 or 1 sets `src_low` to 1; codes 2 to 7 set `src_low` to 0 and `div_log2` to 8 minus the code (code 2 gives divide by 64, code 7 divide by 2).
- R5: A `halt` in run mode with idle enable clear moves `pwr_mode` to 3 (sleep) on the next cycle, with `cpu_run` and `sys_clk_en` both 0.
- R6: A `halt` in run mode with idle enable set moves to mode 1 (idle with clock, `cpu_run` 0, `sys_clk_en` 1) when `periph_keep` is 1, and to mode 2 (idle without clock, both enables 0) when it is 0.
- R7: `wake` in any low-power mode returns `pwr_mode` to 0 on the next cycle; `wake` in run mode and `halt` outside run mode have no effect.
- R8: The high-speed ready flag clears one cycle after the block is in mode 3 or 2, and sets after 1024 cycles in mode 0 or 1 when `osc_xtal` is 1, after 16 such cycles when `osc_xtal` is 0; it holds through mode 1.
- R9: The low-speed ready flag clears one cycle after the block is in mode 3 and sets 2 cycles after leaving it or after reset; other modes leave it unchanged.
- R10: While the programmed selection is a high-speed clock, fast-wake (bit 4) is set, `osc_xtal` is 1 and the high-speed ready flag is 0, `src_low` is 1; it returns to the programmed selection in the same cycle the flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| halt | input | 1 | CPU halt request |
| wake | input | 1 | Wake-up event |
| osc_xtal | input | 1 | High-speed oscillator is crystal type (1) or RC type (0) |
| periph_keep | input | 1 | Keep the system clock during idle |
| src_low | output | 1 | System clock taken from the low-speed source |
| div_log2 | output | 3 | High-speed divider exponent (0 = undivided) |
| cpu_run | output | 1 | CPU run enable |
| sys_clk_en | output | 1 | System clock enable |
| pwr_mode | output | 2 | 0 run, 1 idle with clock, 2 idle without clock, 3 sleep |

## Verification
Writes, halts and wakes all take effect one clock edge after they are captured, and the clock-select outputs follow the register combinationally, so the bench drives on the falling edge and samples on the following falling edge. Flag clearing lags the mode change by one further edge, and the bench checks it one cycle after the mode check. Settle timing is checked by counting edges from the cycle run mode is first visible: the flag must still be low one edge before the expected count (16, 1024, or 2) and high on the count itself, which also catches off-by-one counters.

// File: rtl/clk_pmode_ctrl.sv
module clk_pmode_ctrl #(
  parameter int XTAL_SETTLE = 1024,
  parameter int RC_SETTLE   = 16,
  parameter int LOW_SETTLE  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       halt,
  input  logic       wake,
  input  logic       osc_xtal,
  input  logic       periph_keep,
  output logic       src_low,
  output logic [2:0] div_log2,
  output logic       cpu_run,
  output logic       sys_clk_en,
  output logic [1:0] pwr_mode
);
  localparam int HW = $clog2(XTAL_SETTLE + 1);
  localparam int LW = $clog2(LOW_SETTLE + 1);
  localparam logic [HW-1:0] HI_X_LAST  = HW'(XTAL_SETTLE - 1);
  localparam logic [HW-1:0] HI_RC_LAST = HW'(RC_SETTLE - 1);
  localparam logic [LW-1:0] LO_LAST    = LW'(LOW_SETTLE - 1);

  typedef enum logic [1:0] {M_RUN = 2'd0, M_IDLE1 = 2'd1, M_IDLE0 = 2'd2, M_SLEEP = 2'd3} mode_t;

  mode_t           mode;
  logic [2:0]      div_code;
  logic            fast_wake, idle_en, hi_direct;
  logic            hi_rdy, lo_rdy;
  logic [HW-1:0]   hi_cnt;
  logic [LW-1:0]   lo_cnt;
  logic [HW-1:0]   hi_last;
  logic            prog_low, fast_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_code  <= 3'd0;
      fast_wake <= 1'b0;
      idle_en   <= 1'b1;
      hi_direct <= 1'b1;
    end else if (reg_wr) begin
      div_code  <= reg_wdata[7:5];
      fast_wake <= reg_wdata[4];
      idle_en   <= reg_wdata[1];
      hi_direct <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= M_RUN;
    else begin
      case (mode)
        M_RUN: if (halt) begin
          if (!idle_en)        mode <= M_SLEEP;
          else if (periph_keep) mode <= M_IDLE1;
          else                 mode <= M_IDLE0;
        end
        default: if (wake) mode <= M_RUN;
      endcase
    end
  end

  assign hi_last = osc_xtal ? HI_X_LAST : HI_RC_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      hi_rdy <= 1'b0;
    end else if (mode == M_SLEEP || mode == M_IDLE0) begin
      hi_cnt <= '0;
      hi_rdy <= 1'b0;
    end else if (!hi_rdy) begin
      if (hi_cnt >= hi_last) hi_rdy <= 1'b1;
      else                   hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      lo_rdy <= 1'b0;
    end else if (mode == M_SLEEP) begin
      lo_cnt <= '0;
      lo_rdy <= 1'b0;
    end else if (!lo_rdy) begin
      if (lo_cnt >= LO_LAST) lo_rdy <= 1'b1;
      else                   lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assign prog_low  = !hi_direct && (div_code[2:1] == 2'b00);
  assign fast_hold = !prog_low && fast_wake && osc_xtal && !hi_rdy;
  assign src_low   = prog_low || fast_hold;
  assign div_log2  = (hi_direct || prog_low) ? 3'd0 : 3'(4'd8 - {1'b0, div_code});

  assign cpu_run    = (mode == M_RUN);
  assign sys_clk_en = (mode == M_RUN) || (mode == M_IDLE1);
  assign pwr_mode   = mode;
  assign reg_rdata  = {div_code, fast_wake, lo_rdy, hi_rdy, idle_en, hi_direct};

  // R1
  reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reg_rdata == 8'h03 && pwr_mode == 2'd0));

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[7:4] == $past(reg_wdata[7:4]) && reg_rdata[1:0] == $past(reg_wdata[1:0])));

  // R5
  halt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd0 && halt && !reg_rdata[1]) |=> (pwr_mode == 2'd3 && !sys_clk_en));

  // R6
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd0 && halt && reg_rdata[1]) |=> (pwr_mode == ($past(periph_keep) ? 2'd1 : 2'd2)));

  // R7
  wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0 && wake) |=> cpu_run);

  // R7
  halt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0 && !wake) |=> $stable(pwr_mode));

  // R8
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3 || pwr_mode == 2'd2) |=> !reg_rdata[2]);

  // R8
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[2]) |-> $past(sys_clk_en));

  // R9
  lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3) |=> !reg_rdata[3]);

  // R3
  direct_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && reg_rdata[2]) |-> (!src_low && div_log2 == 3'd0));
endmodule

// File: tb/clk_pmode_ctrl_tb_top.sv
module clk_pmode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, halt = 1'b0, wake = 1'b0, osc_xtal = 1'b0, periph_keep = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic src_low, cpu_run, sys_clk_en;
  logic [2:0] div_log2;
  logic [1:0] pwr_mode;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_pmode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .halt(halt), .wake(wake), .osc_xtal(osc_xtal), .periph_keep(periph_keep),
    .src_low(src_low), .div_log2(div_log2), .cpu_run(cpu_run), .sys_clk_en(sys_clk_en),
    .pwr_mode(pwr_mode));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_halt();
    halt = 1'b1; tick(); halt = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(); wake = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; osc_xtal = 1'b0;
    tick(3);
    rst_n = 1'b1;
    chk("R1 rdata", reg_rdata, 32'h03);
    chk("R1 mode", pwr_mode, 0);
    chk("R1 enables", {cpu_run, sys_clk_en}, 2'b11);
    tick();
    chk("R9 lo after 1", reg_rdata[3], 0);
    tick();
    chk("R9 lo after 2", reg_rdata[3], 1);
    tick(13);
    chk("R8 hi rc after 15", reg_rdata[2], 0);
    tick();
    chk("R8 hi rc after 16", reg_rdata[2], 1);
  endtask

  task automatic t_write();
    wr(8'hFF);
    chk("R2 write ones", reg_rdata, 32'hFF);
    wr(8'h00);
    chk("R2 flags ignore write", reg_rdata, 32'h0C);
  endtask

  task automatic t_clksel();
    for (int c = 0; c < 8; c++) begin
      wr(8'((c << 5) | 2));
      if (c < 2) chk("R4 low src", src_low, 1);
      else begin
        chk("R4 high src", src_low, 0);
        chk("R4 divider", div_log2, 32'(8 - c));
      end
    end
    wr(8'h43);
    chk("R3 direct src", src_low, 0);
    chk("R3 direct div", div_log2, 0);
  endtask

  task automatic t_sleep();
    wr(8'h00);
    pulse_halt();
    chk("R5 mode", pwr_mode, 3);
    chk("R5 enables", {cpu_run, sys_clk_en}, 2'b00);
    tick();
    chk("R8 R9 flags cleared", reg_rdata[3:2], 2'b00);
    pulse_halt();
    chk("R7 halt ignored in sleep", pwr_mode, 3);
    pulse_wake();
    chk("R7 wake to run", pwr_mode, 0);
    chk("R7 cpu_run", cpu_run, 1);
    tick();
    chk("R9 lo 1 after wake", reg_rdata[3], 0);
    tick();
    chk("R9 lo 2 after wake", reg_rdata[3], 1);
    tick(13);
    chk("R8 hi 15 after wake", reg_rdata[2], 0);
    tick();
    chk("R8 hi 16 after wake", reg_rdata[2], 1);
    pulse_wake();
    chk("R7 wake ignored in run", pwr_mode, 0);
  endtask

  task automatic t_idle();
    wr(8'h02);
    periph_keep = 1'b1;
    pulse_halt();
    chk("R6 idle1 mode", pwr_mode, 1);
    chk("R6 idle1 enables", {cpu_run, sys_clk_en}, 2'b01);
    tick(3);
    chk("R8 hi held in idle1", reg_rdata[2], 1);
    pulse_wake();
    chk("R7 wake from idle1", pwr_mode, 0);
    periph_keep = 1'b0;
    pulse_halt();
    chk("R6 idle0 mode", pwr_mode, 2);
    chk("R6 idle0 enables", {cpu_run, sys_clk_en}, 2'b00);
    tick();
    chk("R8 hi cleared idle0", reg_rdata[2], 0);
    chk("R9 lo kept idle0", reg_rdata[3], 1);
    pulse_wake();
    chk("R7 wake from idle0", pwr_mode, 0);
    tick(16);
    chk("R8 hi back after idle0", reg_rdata[2], 1);
  endtask

  task automatic t_xtal();
    osc_xtal = 1'b1;
    wr(8'h13);
    periph_keep = 1'b0;
    pulse_halt();
    tick();
    chk("R10 low while settling", src_low, 1);
    pulse_wake();
    tick(1023);
    chk("R8 xtal hi after 1023", reg_rdata[2], 0);
    chk("R10 still low", src_low, 1);
    tick();
    chk("R8 xtal hi after 1024", reg_rdata[2], 1);
    chk("R10 switch back", src_low, 0);
    chk("R10 div", div_log2, 0);
    wr(8'h03);
    pulse_halt();
    tick();
    chk("R10 no fast wake", src_low, 0);
    pulse_wake();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_write();
    t_clksel();
    t_sleep();
    t_idle();
    t_xtal();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule